// File: doc/BRIEF.md
# Action-Qualified PWM Generator

This block is one PWM timebase with two compare channels and two outputs, A and B. A counter runs either in down-only mode, reloading from a period value each time it reaches zero, or in up/down mode, climbing from zero to the period value and then falling back. Each cycle the current count is tested against zero, the period value and both compare values. Compare matches are tagged with the counting direction, which gives six distinct count events.

Every output edge comes from a per-output action word. For each event the word holds a two-bit code that leaves the output alone, toggles it, drives it low or drives it high. Events also set sticky status bits, feed a level interrupt through an enable mask and produce a one-cycle trigger pulse for a converter or DMA engine. The period and both compare values are shadowed. Each one can take a write at once or hold it until the counter next sits at zero, so a running waveform can be retimed without glitches. Configuration arrives on a plain write strobe with a 3-bit address.

Top module: `pwm_aq_gen`

## Requirements
- R1: After the asynchronous active-low reset, every register is zero. The count, the direction flag, both outputs, all status bits, the interrupt and the trigger read 0.
- R2: With control bit 0 (run) set and control bit 1 (mode) clear, the count steps down by one each cycle. When it is 0 it reloads the period value, so one period lasts period+1 cycles. The direction flag reads 0.
- R3: With run set and mode set, the count rises by one per cycle while the direction flag is 1. The flag turns 0 on the cycle after the count reaches the period value and turns 1 on the cycle after the count reaches 0. A period value of 0 holds the count at 0.
- R4: With run clear, the count, the direction flag, both outputs and the status bits hold, and no event, status change or trigger occurs.
- R5: Event index 0 is count==0 and index 1 is count==period. Index 2 and index 3 are count==compare A with the flag at 1 and at 0. Index 4 and index 5 are the same for compare B. In down-only mode every compare match is the falling kind.
- R6: Each output has a 12-bit action word that holds the code for event i at bits 2i+1:2i. Code 00 keeps the output, 01 inverts it, 10 drives 0 and 11 drives 1. The output changes on the cycle after the event.
- R7: When several events with non-zero codes coincide, one code decides the output. Compare B outranks compare A, compare A outranks period, and period outranks zero.
- R8: Event i sets raw status bit i one cycle after the event. Masked status is raw AND the interrupt-enable bits 5:0 of the event-enable word, and the interrupt output is high while any masked bit is set.
- R9: Writing address 7 clears every raw status bit whose data bit is 1. An event in the same cycle keeps its bit set.
- R10: The trigger output pulses for one cycle, one cycle after any event whose trigger-enable bit is set. Bits 13:8 of the event-enable word map to events 0 to 5.
- R11: The write map is: 0 control, 1 period, 2 compare A, 3 compare B, 4 action A, 5 action B, 6 event enables, 7 status clear. Control bits 2, 3 and 4 select deferred update for period, compare A and compare B. A deferred write takes effect at the next cycle in which the running counter is 0, and the reload in that cycle already uses the new period. Otherwise a write takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| count_o | output | CNT_W | Current count |
| count_up_o | output | 1 | Direction flag, 1 while rising |
| irq_o | output | 1 | Interrupt level |
| trig_o | output | 1 | Trigger pulse |
| raw_status_o | output | 6 | Raw event status |
| masked_status_o | output | 6 | Raw status AND interrupt enables |

## Verification
The bench builds the block with an 8-bit counter, so every period it programs (0, 1, 2 and 5) completes in a handful of cycles. That makes it practical to move compare A across every position from zero to the period value, with compare B mirrored against it, in both counting modes and under four action patterns. Degenerate periods and compare values equal to zero or to the period are reached this way, and those are the cases where several events coincide. Directed sequences then cover the priority order, the deferred reload, a status clear that lands on an event, and a stopped counter.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int unsigned NUM_EV = 6;
  localparam int unsigned ACT_W  = 2 * NUM_EV;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned NUM_SHD = 3;

  // event indices
  localparam int unsigned EV_ZERO = 0;
  localparam int unsigned EV_PER  = 1;
  localparam int unsigned EV_AUP  = 2;
  localparam int unsigned EV_ADN  = 3;
  localparam int unsigned EV_BUP  = 4;
  localparam int unsigned EV_BDN  = 5;

  // control bits
  localparam int unsigned CTRL_RUN     = 0;
  localparam int unsigned CTRL_UPDN    = 1;
  localparam int unsigned CTRL_DEF_LSB = 2;

  // write map
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACTA = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACTB = 3'd5;
  localparam logic [ADDR_W-1:0] A_EVEN = 3'd6;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd7;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              at_zero_i,
  output logic              run_o,
  output logic              updn_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  per_rel_o,
  output logic [CNT_W-1:0]  cmpa_o,
  output logic [CNT_W-1:0]  cmpb_o,
  output logic [ACT_W-1:0]  act_a_o,
  output logic [ACT_W-1:0]  act_b_o,
  output logic [NUM_EV-1:0] irq_en_o,
  output logic [NUM_EV-1:0] trig_en_o,
  output logic [NUM_EV-1:0] clr_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [ACT_W-1:0]  act_a_q, act_b_q;
  logic [NUM_EV-1:0] irq_en_q, trig_en_q;
  logic [NUM_SHD-1:0][CNT_W-1:0] shd_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      act_a_q   <= '0;
      act_b_q   <= '0;
      irq_en_q  <= '0;
      trig_en_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: ctrl_q <= wr_data_i[CTRL_W-1:0];
        A_ACTA: act_a_q <= wr_data_i[ACT_W-1:0];
        A_ACTB: act_b_q <= wr_data_i[ACT_W-1:0];
        A_EVEN: begin
          irq_en_q  <= wr_data_i[NUM_EV-1:0];
          trig_en_q <= wr_data_i[8 +: NUM_EV];
        end
        default: ;
      endcase
    end
  end

  // period, compare A, compare B: shadow plus active copy
  for (genvar g = 0; g < NUM_SHD; g++) begin : g_shd
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(int'(A_PER) + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[g] <= '0;
        cur_q[g] <= '0;
      end else if (hit) begin
        shd_q[g] <= wr_data_i[CNT_W-1:0];
        if (!ctrl_q[CTRL_DEF_LSB+g]) cur_q[g] <= wr_data_i[CNT_W-1:0];
      end else if (at_zero_i) begin
        cur_q[g] <= shd_q[g];
      end
    end
  end

  assign run_o     = ctrl_q[CTRL_RUN];
  assign updn_o    = ctrl_q[CTRL_UPDN];
  assign per_o     = cur_q[0];
  assign per_rel_o = shd_q[0];
  assign cmpa_o    = cur_q[1];
  assign cmpb_o    = cur_q[2];
  assign act_a_o   = act_a_q;
  assign act_b_o   = act_b_q;
  assign irq_en_o  = irq_en_q;
  assign trig_en_o = trig_en_q;
  assign clr_o     = (wr_en_i && wr_addr_i == A_CLR) ? wr_data_i[NUM_EV-1:0] : '0;
endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             updn_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] per_rel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (run_i) begin
      if (!updn_i) begin
        up_d  = 1'b0;
        cnt_d = (cnt_q == '0) ? per_rel_i : cnt_q - 1'b1;
      end else if (up_q) begin
        if (cnt_q >= per_i) begin
          up_d  = 1'b0;
          cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        if (per_i != '0) begin
          up_d  = 1'b1;
          cnt_d = CNT_W'(1);
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
endmodule

// File: rtl/pwm_aq_action.sv
module pwm_aq_action
  import pwm_aq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [ACT_W-1:0]  act_i,
  output logic              pwm_o
);
  act_e sel;
  logic pwm_q, pwm_d;

  // ascending scan: later (higher index) events win
  always_comb begin
    sel = ACT_KEEP;
    for (int i = 0; i < NUM_EV; i++) begin
      if (ev_i[i] && act_e'(act_i[2*i +: 2]) != ACT_KEEP) sel = act_e'(act_i[2*i +: 2]);
    end
    case (sel)
      ACT_TOGGLE: pwm_d = ~pwm_q;
      ACT_LOW:    pwm_d = 1'b0;
      ACT_HIGH:   pwm_d = 1'b1;
      default:    pwm_d = pwm_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_aq_status.sv
module pwm_aq_status
  import pwm_aq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [NUM_EV-1:0] clr_i,
  input  logic [NUM_EV-1:0] irq_en_i,
  input  logic [NUM_EV-1:0] trig_en_i,
  output logic [NUM_EV-1:0] raw_o,
  output logic [NUM_EV-1:0] masked_o,
  output logic              irq_o,
  output logic              trig_o
);
  logic [NUM_EV-1:0] raw_q;
  logic              trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      raw_q  <= (raw_q & ~clr_i) | ev_i;   // set beats clear
      trig_q <= |(ev_i & trig_en_i);
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & irq_en_i;
  assign irq_o    = |masked_o;
  assign trig_o   = trig_q;
endmodule

// File: rtl/pwm_aq_gen.sv
module pwm_aq_gen
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              count_up_o,
  output logic              irq_o,
  output logic              trig_o,
  output logic [NUM_EV-1:0] raw_status_o,
  output logic [NUM_EV-1:0] masked_status_o
);
  localparam int unsigned NUM_OUT = 2;

  logic              run, updn, at_zero, dir_up;
  logic [CNT_W-1:0]  per_act, per_rel, cmpa_act, cmpb_act, cnt;
  logic [ACT_W-1:0]  act_a, act_b;
  logic [NUM_EV-1:0] irq_en, trig_en, clr, ev;
  logic [NUM_OUT-1:0][ACT_W-1:0] act_w;
  logic [NUM_OUT-1:0] pwm;

  pwm_aq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .at_zero_i (at_zero),
    .run_o     (run),
    .updn_o    (updn),
    .per_o     (per_act),
    .per_rel_o (per_rel),
    .cmpa_o    (cmpa_act),
    .cmpb_o    (cmpb_act),
    .act_a_o   (act_a),
    .act_b_o   (act_b),
    .irq_en_o  (irq_en),
    .trig_en_o (trig_en),
    .clr_o     (clr)
  );

  pwm_aq_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni,
    .run_i     (run),
    .updn_i    (updn),
    .per_i     (per_act),
    .per_rel_i (per_rel),
    .cnt_o     (cnt),
    .up_o      (dir_up)
  );

  assign at_zero = run && (cnt == '0);

  always_comb begin
    ev = '0;
    if (run) begin
      ev[EV_ZERO] = (cnt == '0);
      ev[EV_PER]  = (cnt == per_act);
      ev[EV_AUP]  = (cnt == cmpa_act) &&  dir_up;
      ev[EV_ADN]  = (cnt == cmpa_act) && !dir_up;
      ev[EV_BUP]  = (cnt == cmpb_act) &&  dir_up;
      ev[EV_BDN]  = (cnt == cmpb_act) && !dir_up;
    end
  end

  assign act_w = {act_b, act_a};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pwm_aq_action u_act (
      .clk_i, .rst_ni,
      .ev_i  (ev),
      .act_i (act_w[g]),
      .pwm_o (pwm[g])
    );
  end

  pwm_aq_status u_st (
    .clk_i, .rst_ni,
    .ev_i      (ev),
    .clr_i     (clr),
    .irq_en_i  (irq_en),
    .trig_en_i (trig_en),
    .raw_o     (raw_status_o),
    .masked_o  (masked_status_o),
    .irq_o     (irq_o),
    .trig_o    (trig_o)
  );

  assign pwm_a_o    = pwm[0];
  assign pwm_b_o    = pwm[1];
  assign count_o    = cnt;
  assign count_up_o = dir_up;
endmodule

// File: rtl/pwm_aq_gen_chk.sv
module pwm_aq_gen_chk
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              updn_i,
  input logic [CNT_W-1:0]  per_i,
  input logic [NUM_EV-1:0] ev_i,
  input logic [NUM_EV-1:0] clr_i,
  input logic [NUM_EV-1:0] trig_en_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              count_up_i,
  input logic              pwm_a_i,
  input logic              pwm_b_i,
  input logic [NUM_EV-1:0] raw_i,
  input logic              trig_i
);
  // R2
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !updn_i && count_i != '0) |=> (count_i == $past(count_i) - 1'b1));

  // R3
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && updn_i && count_up_i && count_i < per_i) |=> (count_i == $past(count_i) + 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(count_i) && $stable(pwm_a_i) && $stable(pwm_b_i) && !trig_i));

  // R6
  edge_has_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pwm_a_i) || !$stable(pwm_b_i)) |-> $past(|ev_i));

  // R8
  status_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((raw_i & $past(ev_i)) == $past(ev_i)));

  // R9
  status_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~ev_i)) |=> ((raw_i & $past(clr_i & ~ev_i)) == '0));

  // R10
  trig_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |-> $past(|(ev_i & trig_en_i)));
endmodule

bind pwm_aq_gen pwm_aq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run),
  .updn_i     (updn),
  .per_i      (per_act),
  .ev_i       (ev),
  .clr_i      (clr),
  .trig_en_i  (trig_en),
  .count_i    (count_o),
  .count_up_i (count_up_o),
  .pwm_a_i    (pwm_a_o),
  .pwm_b_i    (pwm_b_o),
  .raw_i      (raw_status_o),
  .trig_i     (trig_o)
);

// File: tb/pwm_aq_gen_tb_top.sv
module pwm_aq_gen_tb_top;
  import pwm_aq_pkg::*;
  localparam int unsigned CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [15:0]   wd = '0;
  logic          pwm_a, pwm_b, cup, irq, trig;
  logic [CW-1:0] cnt;
  logic [5:0]    raw, msk;

  pwm_aq_gen #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(wd),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .count_o(cnt), .count_up_o(cup),
    .irq_o(irq), .trig_o(trig), .raw_status_o(raw), .masked_status_o(msk)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [CW-1:0] m_cnt, m_per, m_per_s, m_ca, m_ca_s, m_cb, m_cb_s;
  logic          m_up, m_a, m_b, m_trig;
  logic [4:0]    m_ctrl;
  logic [11:0]   m_acta, m_actb;
  logic [5:0]    m_ien, m_ten, m_raw;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic apply(input logic cur, input logic [11:0] w, input logic [5:0] ev);
    logic [1:0] code = 2'b00;
    for (int i = 0; i < 6; i++) if (ev[i] && w[2*i +: 2] != 2'b00) code = w[2*i +: 2];
    case (code)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_per = '0; m_per_s = '0; m_ca = '0; m_ca_s = '0; m_cb = '0; m_cb_s = '0;
    m_up = 0; m_a = 0; m_b = 0; m_trig = 0; m_ctrl = '0; m_acta = '0; m_actb = '0;
    m_ien = '0; m_ten = '0; m_raw = '0;
  endtask

  task automatic model_step(input logic w, input logic [2:0] a, input logic [15:0] d);
    logic run, ud, az;
    logic [5:0] ev, clr;
    logic [CW-1:0] n_cnt;
    logic n_up;
    run = m_ctrl[0]; ud = m_ctrl[1];
    ev = '0;
    if (run) begin
      ev[0] = (m_cnt == 0);
      ev[1] = (m_cnt == m_per);
      if (m_cnt == m_ca) ev[m_up ? 2 : 3] = 1'b1;
      if (m_cnt == m_cb) ev[m_up ? 4 : 5] = 1'b1;
    end
    n_cnt = m_cnt; n_up = m_up;
    if (run) begin
      if (!ud) begin
        n_up = 0;
        n_cnt = (m_cnt == 0) ? m_per_s : m_cnt - 1'b1;
      end else if (m_up) begin
        if (m_cnt >= m_per) begin n_up = 0; n_cnt = (m_cnt == 0) ? m_cnt : m_cnt - 1'b1; end
        else n_cnt = m_cnt + 1'b1;
      end else if (m_cnt == 0) begin
        if (m_per != 0) begin n_up = 1; n_cnt = CW'(1); end
      end else n_cnt = m_cnt - 1'b1;
    end
    az = run && (m_cnt == 0);
    m_a = apply(m_a, m_acta, ev);
    m_b = apply(m_b, m_actb, ev);
    clr = (w && a == A_CLR) ? d[5:0] : 6'h0;
    m_raw = (m_raw & ~clr) | ev;
    m_trig = |(ev & m_ten);
    m_cnt = n_cnt; m_up = n_up;
    // shadowed registers
    if (w && a == A_PER) begin m_per_s = d[CW-1:0]; if (!m_ctrl[2]) m_per = d[CW-1:0]; end
    else if (az) m_per = m_per_s;
    if (w && a == A_CMPA) begin m_ca_s = d[CW-1:0]; if (!m_ctrl[3]) m_ca = d[CW-1:0]; end
    else if (az) m_ca = m_ca_s;
    if (w && a == A_CMPB) begin m_cb_s = d[CW-1:0]; if (!m_ctrl[4]) m_cb = d[CW-1:0]; end
    else if (az) m_cb = m_cb_s;
    if (w && a == A_ACTA) m_acta = d[11:0];
    if (w && a == A_ACTB) m_actb = d[11:0];
    if (w && a == A_EVEN) begin m_ien = d[5:0]; m_ten = d[13:8]; end
    if (w && a == A_CTRL) m_ctrl = d[4:0];
  endtask

  task automatic compare_all();
    string cr;
    cr = m_ctrl[1] ? "R3" : "R2";
    check(cnt == m_cnt, cr, "count", cnt, m_cnt);
    check(cup == m_up, cr, "direction", cup, m_up);
    check(pwm_a == m_a, "R6", "pwm_a", pwm_a, m_a);
    check(pwm_b == m_b, "R6", "pwm_b", pwm_b, m_b);
    check(raw == m_raw, "R8", "raw status", raw, m_raw);
    check(msk == (m_raw & m_ien), "R8", "masked status", msk, m_raw & m_ien);
    check(irq == |(m_raw & m_ien), "R8", "irq", irq, |(m_raw & m_ien));
    check(trig == m_trig, "R10", "trigger", trig, m_trig);
  endtask

  task automatic tick(input logic w, input logic [2:0] a, input logic [15:0] d);
    we = w; addr = a; wd = d;
    model_step(w, a, d);
    @(negedge clk);
    we = 1'b0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 16'h0);
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 64 && int'(cnt) != v; i++) tick(1'b0, 3'd0, 16'h0);
  endtask

  task automatic setup(input logic [15:0] ctrl, input int per, input int ca, input int cb,
                       input logic [11:0] aa, input logic [11:0] ab, input logic [15:0] een);
    tick(1'b1, A_CTRL, 16'h0);
    tick(1'b1, A_PER,  16'(per));
    tick(1'b1, A_CMPA, 16'(ca));
    tick(1'b1, A_CMPB, 16'(cb));
    tick(1'b1, A_ACTA, {4'h0, aa});
    tick(1'b1, A_ACTB, {4'h0, ab});
    tick(1'b1, A_EVEN, een);
    tick(1'b1, A_CLR,  16'h003F);
    tick(1'b1, A_CTRL, ctrl);
  endtask

  logic [11:0] pats [4] = '{12'h0B0, 12'h00B, 12'h555, 12'hE10};
  int pers [4] = '{0, 1, 2, 5};

  initial begin
    logic [CW-1:0] h_cnt;
    logic h_a, h_b;
    logic [5:0] h_raw;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cnt == 0 && cup == 0, "R1", "count/dir after reset", cnt, 0);
    check(pwm_a == 0 && pwm_b == 0, "R1", "outputs after reset", {pwm_a, pwm_b}, 0);
    check(raw == 0 && msk == 0 && irq == 0 && trig == 0, "R1", "status after reset", raw, 0);
    compare_all();

    // sweep: modes x periods x compare positions x action patterns (R2 R3 R5 R6 R8 R10 R11)
    for (int ud = 0; ud < 2; ud++)
      for (int pi = 0; pi < 4; pi++)
        for (int ca = 0; ca <= pers[pi]; ca++)
          for (int p = 0; p < 4; p++) begin
            setup(16'(1 | (ud << 1)), pers[pi], ca, pers[pi] - ca, pats[p], pats[(p + 1) % 4],
                  {2'b00, 6'(6'h3F >> p), 2'b00, 6'(6'h15 << (p % 2))});
            idle(3 * (2 * pers[pi] + 2));
          end

    // R5: down-only mode never fires rising compares
    setup(16'h0001, 4, 2, 4, 12'h032, 12'h0C0, 16'h3F3F);
    idle(12);
    check(pwm_a == 1'b0, "R5", "A-up action in down mode", pwm_a, 0);
    check(pwm_b == 1'b1, "R5", "A-down action in down mode", pwm_b, 1);
    check(raw[EV_AUP] == 1'b0 && raw[EV_BUP] == 1'b0, "R5", "rising status in down mode", raw, 6'h2B);
    check(raw[EV_ADN] == 1'b1 && raw[EV_BDN] == 1'b1, "R5", "falling status in down mode", raw, 6'h2B);

    // R7: priority B > A > period > zero
    setup(16'h0001, 3, 0, 0, 12'h84F, 12'h0C2, 16'h0000);
    wait_count(3);
    tick(1'b0, 3'd0, 16'h0);
    check(pwm_a == 1'b1, "R7", "period set", pwm_a, 1);
    wait_count(0);
    tick(1'b0, 3'd0, 16'h0);
    check(pwm_a == 1'b0, "R7", "compare B beats A and zero", pwm_a, 0);
    check(pwm_b == 1'b1, "R7", "compare A beats zero", pwm_b, 1);

    // R9: clear collides with an event
    tick(1'b1, A_CMPA, 16'd2);
    tick(1'b1, A_CMPB, 16'd1);
    idle(8);
    wait_count(0);
    tick(1'b1, A_CLR, 16'h003F);
    check(raw == 6'b000001, "R9", "clear with zero event", raw, 1);
    tick(1'b1, A_CLR, 16'h0001);
    check(raw == 6'b000010, "R9", "clear with period event", raw, 2);

    // R11: deferred period reload
    setup(16'h0005, 5, 1, 2, 12'h000, 12'h000, 16'h0000);
    idle(2);
    wait_count(3);
    tick(1'b1, A_PER, 16'd2);
    wait_count(0);
    tick(1'b0, 3'd0, 16'h0);
    check(cnt == 2, "R11", "deferred period at reload", cnt, 2);
    tick(1'b1, A_CTRL, 16'h0003);
    tick(1'b1, A_PER, 16'd4);
    idle(12);
    check(cnt <= 4, "R11", "immediate period bound", cnt, 4);

    // R4: stopped counter holds everything
    tick(1'b1, A_CTRL, 16'h0002);
    h_cnt = cnt; h_a = pwm_a; h_b = pwm_b; h_raw = raw;
    idle(10);
    check(cnt == h_cnt, "R4", "count held", cnt, h_cnt);
    check(pwm_a == h_a && pwm_b == h_b, "R4", "outputs held", {pwm_a, pwm_b}, {h_a, h_b});
    check(raw == h_raw && trig == 1'b0, "R4", "status held", raw, h_raw);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule